// File: doc/BRIEF.md
# Serial Two-Wire Byte Memory Slave with Paged Writes

This block is a two-wire serial bus slave (I2C protocol) in front of a small byte-wide memory. A master selects it with a device-select byte and can then set the byte pointer, write one byte or a run of bytes, or read bytes starting at a chosen address or at the current pointer. The bus lines come in as plain levels. The slave drives SDA through an active-high pull-down enable, and the board wires that enable as an open-drain output.

Written bytes are not stored straight away. They collect in a page latch, and a STOP starts an internal program cycle of fixed length, counted in system clocks. At the end of that cycle the latched bytes move into the array. For the whole program cycle the slave ignores the bus entirely and drives no acknowledge. A master can therefore poll with device-select bytes until one of them is acknowledged. A `busy` output shows when a program cycle is running.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, `sdaOe` is low and `busy` is low, and every memory byte reads as 0x00.
- R2: Device-select byte layout:
  - Bits [7:4] must equal the type code 4'b1010.
  - Bits [3:1] must equal the chip-select parameter (default 3'b000).
  - Bit [0] is R/W, where 1 means read.
  - The slave acknowledges a matching byte by driving SDA low during the ninth SCL pulse. A mismatch gets no acknowledge, and the slave then ignores the bus until the next START.
- R3: In a write, the byte after the device select sets the pointer from its low 5 bits. The upper 3 bits are ignored. Each data byte is acknowledged, and once the program cycle has run after STOP, each written byte reads back at its address.
- R4: After each written data byte, only the low 3 bits of the pointer increment. Writing past an 8-byte page boundary wraps to the start of the same page, and a later byte overwrites an earlier one.
- R5: A STOP that follows at least one acknowledged data byte raises `busy` on the clock after the STOP is seen. `busy` stays high for exactly PROG_CYCLES clocks. A STOP with no latched data byte starts no program cycle.
- R6: While `busy` is high, no byte is acknowledged, including the slave's own device select, and no address or data is taken in.
- R7: Once the program cycle ends, a write device select is acknowledged, and the following byte is taken as the address.
- R8: A write that is cut short by a repeated START, with no STOP, commits none of its bytes and starts no program cycle.
- R9: A random read returns the byte at the requested address. The sequence is device select with R/W=0, address, repeated START, then device select with R/W=1. Data is sent MSB first.
- R10: In a read, a master ACK (SDA low in the ninth pulse) moves on to the next address, and the address wraps from 31 to 0. A master NACK ends the read with SDA released.
- R11: A read without an address byte returns the byte at the current pointer. The pointer is one past the last byte read, or, after a write, the page base plus the wrapped low bits.
- R12: The slave samples SDA on SCL rising edges. Its SDA drive changes only while SCL is low, except at START/STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level (wired-AND of all drivers) |
| sdaOe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Internal program cycle running |

## Verification
The assertions assume that SCL holds each level for several system clocks and that SDA moves only while SCL is low, except to form START and STOP. Under those conditions, each synchronized edge maps to exactly one bus event, and the slave's drive changes fall inside a low phase. The bench master gives every SCL quarter-phase 8 clocks and changes SDA only after SCL has fallen. It never issues a START while the slave is driving SDA, so the open-drain line is never contended.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // One-cycle commands from control to datapath
  typedef struct packed {
    logic shiftIn;    // take sampled SDA into receive register
    logic loadAddr;   // receive register -> pointer
    logic writeByte;  // receive register -> page latch, bump low pointer bits
    logic startProg;  // STOP seen: begin program cycle if latch holds data
    logic discard;    // START seen: drop latched bytes
    logic loadTx;     // memory at pointer -> transmit register
    logic shiftTx;    // advance transmit register by one bit
    logic incPtr;     // full-width pointer increment after a read byte
  } eep_strb_t;

  // Bus events derived from the synchronized lines
  typedef struct packed {
    logic sclHigh;
    logic sdaLvl;
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } eep_line_t;

endpackage

// File: rtl/eep_dpath.sv
module eep_dpath
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  eep_strb_t strb,
  output eep_line_t line,
  output logic [7:0] rxByte,
  output logic      txNext,
  output logic      rdMsb,
  output logic      busy
);
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int PAGE_SIZE = 1 << PAGE_W;
  localparam int PCNT_W    = $clog2(PROG_CYCLES + 1);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  always_comb begin
    line.sclHigh   = sclSync[1];
    line.sdaLvl    = sdaSync[1];
    line.sclRise   = sclSync[1] & ~sclPrev;
    line.sclFall   = ~sclSync[1] & sclPrev;
    line.startSeen = sclSync[1] & sclPrev & sdaPrev & ~sdaSync[1];
    line.stopSeen  = sclSync[1] & sclPrev & ~sdaPrev & sdaSync[1];
  end

  logic [7:0]          rxReg, txReg;
  logic [ADDR_W-1:0]   ptr;
  logic [7:0]          mem [MEM_DEPTH];
  logic [7:0]          pageData [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] pageValid;
  logic [PCNT_W-1:0]   progCnt;

  assign rxByte = rxReg;
  assign txNext = txReg[6];
  assign rdMsb  = mem[ptr][7];
  assign busy   = (progCnt != '0);

  // Shift registers and pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= '0;
      ptr   <= '0;
    end else begin
      if (strb.shiftIn)   rxReg <= {rxReg[6:0], line.sdaLvl};
      if (strb.loadTx)    txReg <= mem[ptr];
      else if (strb.shiftTx) txReg <= {txReg[6:0], 1'b0};
      if (strb.loadAddr)  ptr <= rxReg[ADDR_W-1:0];
      else if (strb.writeByte) ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
      else if (strb.incPtr) ptr <= ptr + ADDR_W'(1);
    end
  end

  // Page latch, program cycle and array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageValid <= '0;
      progCnt   <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_SIZE; i++) pageData[i] <= '0;
    end else begin
      if (progCnt != '0) begin
        progCnt <= progCnt - PCNT_W'(1);
        if (progCnt == PCNT_W'(1)) begin
          for (int i = 0; i < PAGE_SIZE; i++)
            if (pageValid[i])
              mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageData[i];
          pageValid <= '0;
        end
      end else if (strb.startProg && (pageValid != '0)) begin
        progCnt <= PCNT_W'(PROG_CYCLES);
      end else if (strb.discard) begin
        pageValid <= '0;
      end else if (strb.writeByte) begin
        pageData[ptr[PAGE_W-1:0]]  <= rxReg;
        pageValid[ptr[PAGE_W-1:0]] <= 1'b1;
      end
    end
  end

  // Page writes never move the pointer out of its page
  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  // Read pointer wraps from top of memory to zero
  assert_read_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incPtr && ptr == '1) |=> ptr == '0);

  // A program cycle only ever begins right after a bus STOP
  assert_prog_after_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(line.stopSeen));

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter logic [2:0] CHIP_SEL = 3'b000
) (
  input  logic       clk,
  input  logic       rstN,
  input  eep_line_t  line,
  input  logic [7:0] rxByte,
  input  logic       txNext,
  input  logic       rdMsb,
  input  logic       busy,
  output eep_strb_t  strb,
  output logic       sdaOe
);
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} ctrl_st_e;
  typedef enum logic [1:0] {K_DEV, K_ADDR, K_DATA} rx_kind_e;

  ctrl_st_e st, stN;
  rx_kind_e kind, kindN;
  logic [3:0] cnt, cntN;
  logic oeN, readMode, rdN, nack, nackN;
  logic selHit;

  assign selHit = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == CHIP_SEL);

  always_comb begin
    stN = st; kindN = kind; cntN = cnt; oeN = sdaOe;
    rdN = readMode; nackN = nack; strb = '0;
    if (busy) begin
      stN = ST_IDLE; oeN = 1'b0;
    end else if (line.startSeen) begin
      stN = ST_RX; kindN = K_DEV; cntN = '0; oeN = 1'b0; strb.discard = 1'b1;
    end else if (line.stopSeen) begin
      stN = ST_IDLE; oeN = 1'b0; strb.startProg = 1'b1;
    end else begin
      case (st)
        ST_RX: begin
          if (line.sclRise && cnt != 4'd8) begin
            strb.shiftIn = 1'b1; cntN = cnt + 4'd1;
          end else if (line.sclFall && cnt == 4'd8) begin
            cntN = '0;
            case (kind)
              K_DEV: begin
                if (selHit) begin oeN = 1'b1; stN = ST_ACK; rdN = rxByte[0]; end
                else stN = ST_IDLE;
              end
              K_ADDR: begin strb.loadAddr = 1'b1; oeN = 1'b1; stN = ST_ACK; end
              default: begin strb.writeByte = 1'b1; oeN = 1'b1; stN = ST_ACK; end
            endcase
          end
        end
        ST_ACK: if (line.sclFall) begin
          if (kind == K_DEV && readMode) begin
            strb.loadTx = 1'b1; oeN = ~rdMsb; cntN = 4'd1; stN = ST_TX;
          end else begin
            oeN = 1'b0; stN = ST_RX;
            kindN = (kind == K_DEV) ? K_ADDR : K_DATA;
          end
        end
        ST_TX: if (line.sclFall) begin
          if (cnt == 4'd8) begin
            oeN = 1'b0; strb.incPtr = 1'b1; stN = ST_MACK;
          end else begin
            strb.shiftTx = 1'b1; oeN = ~txNext; cntN = cnt + 4'd1;
          end
        end
        ST_MACK: begin
          if (line.sclRise) nackN = line.sdaLvl;
          if (line.sclFall) begin
            if (!nack) begin
              strb.loadTx = 1'b1; oeN = ~rdMsb; cntN = 4'd1; stN = ST_TX;
            end else begin
              oeN = 1'b0; stN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_IDLE; kind <= K_DEV; cnt <= '0;
      sdaOe <= 1'b0; readMode <= 1'b0; nack <= 1'b1;
    end else begin
      st <= stN; kind <= kindN; cnt <= cntN;
      sdaOe <= oeN; readMode <= rdN; nack <= nackN;
    end
  end

  // Drive on SDA moves only in SCL low phase (or on START/STOP/busy)
  assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> (!line.sclHigh || $past(line.startSeen || line.stopSeen || busy)));

  // A foreign device select is never acknowledged and parks the slave
  assert_foreign_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RX && kind == K_DEV && cnt == 4'd8 && line.sclFall && !selHit &&
     !busy && !line.startSeen && !line.stopSeen) |=> (st == ST_IDLE && !sdaOe));

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eep_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter logic [2:0] CHIP_SEL    = 3'b000,
  parameter int         ADDR_W      = 5,
  parameter int         PAGE_W      = 3,
  parameter int         PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  output logic busy
);
  eep_strb_t  strb;
  eep_line_t  line;
  logic [7:0] rxByte;
  logic       txNext, rdMsb;

  eep_dpath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_dpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .line(line), .rxByte(rxByte), .txNext(txNext), .rdMsb(rdMsb), .busy(busy)
  );

  eep_ctrl #(.DEV_TYPE(DEV_TYPE), .CHIP_SEL(CHIP_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .line(line), .rxByte(rxByte), .txNext(txNext),
    .rdMsb(rdMsb), .busy(busy), .strb(strb), .sdaOe(sdaOe)
  );

  // Deaf during the program cycle: never pulls SDA
  assert_busy_deaf_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

endmodule

// File: tb/test_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module test_eeprom_i2c_slave;
  localparam int PROG  = 600;
  localparam int Q     = 8;
  localparam int LIMIT = 190000;
  localparam logic [7:0] DEV_W = 8'hA0;
  localparam logic [7:0] DEV_R = 8'hA1;

  logic clk = 1'b0;
  logic rstN, sclM, mSda, sdaOe, busy, sdaLine;
  always #2 clk = ~clk;
  assign sdaLine = mSda & ~sdaOe;

  eeprom_i2c_slave #(.PROG_CYCLES(PROG)) i_eeprom_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe), .busy(busy));

  int checks = 0, fails = 0, cycCnt = 0, runLen = 0, lastRun = 0, oeBad = 0;
  logic prevOe = 1'b0;
  logic [7:0] model [32];
  int mPtr = 0;
  logic [7:0] wbuf [16];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(negedge clk) begin
    cycCnt++;
    if (busy) runLen++;
    else if (runLen != 0) begin lastRun = runLen; runLen = 0; end
    if (sdaOe !== prevOe && sclM) oeBad++;
    prevOe = sdaOe;
    if (cycCnt == LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycCnt, LIMIT);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    mSda = 1'b1; tick(Q); sclM = 1'b1; tick(Q); mSda = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic i2cStop();
    mSda = 1'b0; tick(Q); sclM = 1'b1; tick(Q); mSda = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0; tick(Q);
    end
    mSda = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    ack = (sdaLine == 1'b0);
    tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(output logic [7:0] d, input bit masterNack);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sclM = 1'b1; tick(Q); d[i] = sdaLine; tick(Q); sclM = 1'b0; tick(Q);
    end
    mSda = masterNack; tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0; mSda = 1'b1; tick(Q);
  endtask

  task automatic waitBusy();
    while (busy) @(negedge clk);
    tick(4);
  endtask

  // Page write from wbuf; model follows the 3-bit wrap rule
  task automatic doWrite(input logic [7:0] addr, input int n, input string req);
    bit ack;
    int base;
    int p;
    p = addr & 31;
    base = p & ~7;
    i2cStart();
    sendByte(DEV_W, ack); check(ack, "R2", ack, 1);
    sendByte(addr, ack);  check(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], ack); check(ack, req, ack, 1);
      model[base | ((p + i) & 7)] = wbuf[i];
    end
    i2cStop();
    mPtr = base | ((p + n) & 7);
  endtask

  task automatic readRun(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recvByte(d, i == n - 1);
      check(d == model[mPtr], req, d, model[mPtr]);
      mPtr = (mPtr + 1) % 32;
    end
    check(sdaOe == 1'b0, "R10", sdaOe, 0);
  endtask

  task automatic randRead(input logic [7:0] addr, input int n, input string req);
    bit ack;
    i2cStart();
    sendByte(DEV_W, ack); check(ack, "R2", ack, 1);
    sendByte(addr, ack);  check(ack, req, ack, 1);
    i2cStart();
    sendByte(DEV_R, ack); check(ack, "R9", ack, 1);
    mPtr = addr & 31;
    readRun(n, req);
    i2cStop();
  endtask

  task automatic curRead(input int n, input string req);
    bit ack;
    i2cStart();
    sendByte(DEV_R, ack); check(ack, "R11", ack, 1);
    readRun(n, req);
    i2cStop();
  endtask

  initial begin
    bit ack;
    int polls, stamp;
    logic [7:0] d;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    mSda = 1'b1; sclM = 1'b1; rstN = 1'b0;
    tick(5); rstN = 1'b1; tick(5);

    // R1: reset state and an all-zero array
    check(busy == 1'b0, "R1", busy, 0);
    check(sdaOe == 1'b0, "R1", sdaOe, 0);
    randRead(8'd0, 32, "R1");

    // R2: foreign chip select and foreign type code
    i2cStart();
    sendByte(8'hA2, ack); check(!ack, "R2", ack, 0);
    sendByte(8'h05, ack); check(!ack, "R2", ack, 0);
    i2cStop();
    i2cStart();
    sendByte(8'hB0, ack); check(!ack, "R2", ack, 0);
    i2cStop(); tick(4);
    check(busy == 1'b0, "R2", busy, 0);

    // R3/R5/R6/R7: byte write then acknowledge polling
    i2cStart();
    sendByte(DEV_W, ack); check(ack, "R2", ack, 1);
    sendByte(8'd5, ack);  check(ack, "R3", ack, 1);
    sendByte(8'hA5, ack); check(ack, "R3", ack, 1);
    i2cStop();
    stamp = cycCnt;
    model[5] = 8'hA5;
    check(busy == 1'b1, "R5", busy, 1);
    polls = 0;
    do begin
      i2cStart();
      sendByte(DEV_W, ack);
      if (!ack) polls++;
    end while (!ack && polls < 50);
    check(polls >= 1, "R6", polls, 1);
    check(cycCnt - stamp >= PROG - 2*Q, "R7", cycCnt - stamp, PROG);
    check(lastRun == PROG, "R5", lastRun, PROG);
    sendByte(8'd5, ack); check(ack, "R7", ack, 1);
    i2cStart();
    sendByte(DEV_R, ack); check(ack, "R9", ack, 1);
    mPtr = 5;
    readRun(1, "R3");
    i2cStop();

    // R6: a full write attempted during the program cycle is dropped
    wbuf[0] = 8'h3C;
    doWrite(8'd16, 1, "R3");
    i2cStart();
    sendByte(DEV_W, ack); check(!ack, "R6", ack, 0);
    sendByte(8'd18, ack); check(!ack, "R6", ack, 0);
    sendByte(8'h77, ack); check(!ack, "R6", ack, 0);
    i2cStop();
    waitBusy();
    check(lastRun == PROG, "R5", lastRun, PROG);
    randRead(8'd16, 3, "R6");

    // R3: upper address bits ignored
    wbuf[0] = 8'h5A;
    doWrite(8'hE3, 1, "R3");
    waitBusy();
    randRead(8'd3, 1, "R3");

    // R4/R11: page write of 10 bytes from offset 3 of page 8..15
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hD0 + 8'(i);
    doWrite(8'h0B, 10, "R4");
    waitBusy();
    curRead(1, "R11");
    randRead(8'd8, 8, "R4");

    // R8: write cut by repeated START commits nothing
    i2cStart();
    sendByte(DEV_W, ack); check(ack, "R2", ack, 1);
    sendByte(8'd20, ack); check(ack, "R8", ack, 1);
    sendByte(8'h33, ack); check(ack, "R8", ack, 1);
    i2cStart();
    sendByte(DEV_R, ack); check(ack, "R11", ack, 1);
    mPtr = 21;
    readRun(1, "R11");
    i2cStop(); tick(4);
    check(busy == 1'b0, "R8", busy, 0);
    randRead(8'd20, 1, "R8");

    // R5: address-only write starts no program cycle
    i2cStart();
    sendByte(DEV_W, ack); check(ack, "R2", ack, 1);
    sendByte(8'd9, ack);  check(ack, "R5", ack, 1);
    i2cStop(); tick(4);
    check(busy == 1'b0, "R5", busy, 0);
    mPtr = 9;
    curRead(1, "R11");

    // R10: sequential read wraps 31 -> 0
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h80 + 8'(i * 3);
    doWrite(8'd24, 8, "R3");
    waitBusy();
    randRead(8'd30, 4, "R10");
    curRead(1, "R11");

    // R9: sweep every page with an arithmetic pattern, read it all back
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) wbuf[i] = 8'((p * 8 + i) * 37 + 11);
      doWrite(8'(p * 8), 8, "R3");
      waitBusy();
      check(lastRun == PROG, "R5", lastRun, PROG);
    end
    randRead(8'd0, 32, "R9");
    randRead(8'd13, 20, "R9");

    // R12: slave drive moved only while SCL was low
    check(oeBad == 0, "R12", oeBad, 0);

    summary();
    $finish;
  end
endmodule